// File: doc/BRIEF.md
# Transmit Squelch and Idle-Waveform Generator

This block sits between the sampled host data-out pair and the drive of an optical emitter. Each cycle of a fixed sample clock (100 MHz assumed) it receives two bits: the line polarity (1 when the pair is on its negative side) and a level-valid flag (1 when the swing exceeds the negative threshold). A sample counts as negative only when both bits are 1. A squelch state machine stays closed until a run of negative samples lasts long enough. It then passes data to the emitter, and closes again once the line has stayed positive past a timeout.

While closed, the emitter carries an idle square wave. Its half period is a parameter in samples; the default of 50 gives 1 MHz with a 50% duty cycle. A disable input, driven by a jabber or low-light controller elsewhere, blocks data from the emitter and substitutes the idle wave. It does not stop the squelch machine. The block raises a transmit-active flag for collision and jabber logic, and emits a one-cycle start-of-idle pulse when a transmission ends.

The states are ST_QUIET (closed), ST_ARM (measuring a negative run), ST_PASS (data passes) and ST_MARK (one cycle that reports start of idle). The transitions are:
- QUIET or MARK to ARM on a negative sample.
- QUIET or MARK straight to PASS when the run already meets the minimum.
- ARM back to QUIET on a positive sample before the minimum is reached.
- ARM to PASS when the minimum is reached.
- PASS to MARK when the positive run reaches the timeout.
- MARK to QUIET otherwise.

Top module: `tx_squelch_idle`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, and in the first cycle after it, the machine is in ST_QUIET, with emitter dark, transmit-active low and start-of-idle low.
- R2: Outside ST_PASS with the disable low, the emitter shows the idle wave. The wave starts dark when released from reset or from being held in ST_PASS. It toggles every IDLE_HALF samples, so sample i after release is lit exactly when (i / IDLE_HALF) is odd.
- R3: A run of MIN_NEG consecutive negative samples (polarity=1 and level-valid=1) opens the squelch. Transmit-active rises in the sample after the MIN_NEG-th, so at most MIN_NEG samples of a packet are lost.
- R4: A negative run shorter than MIN_NEG, or polarity=1 with level-valid=0, leaves the machine closed and transmit-active low.
- R5: In ST_PASS with the disable low, the emitter is lit in the same sample when the sample is negative, and dark when it is not.
- R6: A run of END_POS consecutive non-negative samples in ST_PASS ends transmission. In the next sample, start-of-idle is high for exactly one cycle and transmit-active is low. This also holds while the disable is high.
- R7: A negative sample inside a positive run shorter than END_POS restarts the run and keeps transmit-active high.
- R8: With the disable high in ST_PASS, data does not reach the emitter. The emitter shows the idle wave, starting dark from the first disabled sample, while transmit-active stays high.
- R9: While closed, the disable has no effect on the emitter waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_neg | input | 1 | Sampled polarity, 1 = negative side |
| din_lvl | input | 1 | Sampled level-valid flag |
| jab_off | input | 1 | Transmit disable from jabber or low-light control |
| emit_on | output | 1 | Optical emitter drive, 1 = lit |
| tx_active | output | 1 | High while the squelch is open |
| soi_pulse | output | 1 | One-cycle start-of-idle report |

## Verification
The disable input and the end-of-transmission timeout can act in the same cycle. The bench raises the disable mid-packet and keeps it high through a full positive run of END_POS samples. The final positive sample is therefore taken while the emitter already shows the substituted idle wave. The bench then expects start-of-idle high and transmit-active low in the very next sample. It also expects the emitter to have followed the idle pattern, counted from the first disabled sample, throughout.

// File: rtl/tx_sq_pkg.sv
package tx_sq_pkg;
    typedef enum logic [1:0] {
        ST_QUIET,
        ST_ARM,
        ST_PASS,
        ST_MARK
    } sq_state_t;
endpackage

// File: rtl/tx_run_len.sv
// Counts consecutive true samples; hit when the current sample completes a run of LIMIT.
module tx_run_len #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    output logic hit
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!in_bit)
            cnt <= '0;
        else if (cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    assign hit = in_bit && (cnt == TOP);
endmodule

// File: rtl/tx_idle_wave.sv
// Square wave, HALF samples per level, restarted dark while hold is high.
module tx_idle_wave #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic wave
);
    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [W-1:0] TOP = W'(HALF - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (hold) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (cnt == TOP) begin
            cnt  <= '0;
            wave <= ~wave;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tx_squelch_idle.sv
module tx_squelch_idle
    import tx_sq_pkg::*;
#(
    parameter int MIN_NEG   = 2,
    parameter int END_POS   = 18,
    parameter int IDLE_HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_neg,
    input  logic din_lvl,
    input  logic jab_off,
    output logic emit_on,
    output logic tx_active,
    output logic soi_pulse
);
    sq_state_t state, nxt;
    logic neg_smp, neg_hit, pos_hit, wave, hold;

    assign neg_smp = din_neg & din_lvl;
    assign hold    = (state == ST_PASS) && !jab_off;

    tx_run_len #(.LIMIT(MIN_NEG)) u_neg_run (
        .clk(clk), .rst_n(rst_n), .in_bit(neg_smp), .hit(neg_hit)
    );

    tx_run_len #(.LIMIT(END_POS)) u_pos_run (
        .clk(clk), .rst_n(rst_n), .in_bit(~neg_smp), .hit(pos_hit)
    );

    tx_idle_wave #(.HALF(IDLE_HALF)) u_wave (
        .clk(clk), .rst_n(rst_n), .hold(hold), .wave(wave)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_QUIET;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_QUIET, ST_MARK: begin
                if (neg_hit)
                    nxt = ST_PASS;
                else if (neg_smp)
                    nxt = ST_ARM;
                else
                    nxt = ST_QUIET;
            end
            ST_ARM: begin
                if (!neg_smp)
                    nxt = ST_QUIET;
                else if (neg_hit)
                    nxt = ST_PASS;
            end
            ST_PASS: begin
                if (pos_hit)
                    nxt = ST_MARK;
            end
            default: nxt = ST_QUIET;
        endcase
    end

    always_comb begin
        emit_on   = wave;
        tx_active = 1'b0;
        soi_pulse = 1'b0;
        unique case (state)
            ST_QUIET, ST_ARM: ;
            ST_PASS: begin
                tx_active = 1'b1;
                emit_on   = jab_off ? wave : neg_smp;
            end
            ST_MARK: soi_pulse = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tx_squelch_idle_chk.sv
module tx_squelch_idle_chk (
    input logic clk,
    input logic rst_n,
    input logic din_neg,
    input logic din_lvl,
    input logic jab_off,
    input logic emit_on,
    input logic tx_active,
    input logic soi_pulse
);
    assert_open_on_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(din_neg && din_lvl));

    assert_pass_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !jab_off && din_neg && din_lvl) |-> emit_on);

    assert_pass_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !jab_off && !din_neg) |-> !emit_on);

    assert_mark_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soi_pulse |=> !soi_pulse);

    assert_mark_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soi_pulse |-> !tx_active);

    assert_fall_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> soi_pulse);

    assert_mark_after_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soi_pulse) |-> $past(tx_active));
endmodule

bind tx_squelch_idle tx_squelch_idle_chk u_chk (.*);

// File: tb/tx_squelch_idle_test.sv
module tx_squelch_idle_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din_neg = 1'b0, din_lvl = 1'b0, jab_off = 1'b0;
    logic emit_on, tx_active, soi_pulse;
    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tx_squelch_idle uut (.*);

    // {neg, lvl, jab, reps[7:0], exp_emit, exp_act, exp_soi}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {3'b000, 8'd2,  3'b000},  // R1 quiet, idle dark
        {3'b110, 8'd1,  3'b000},  // R4 one negative sample
        {3'b000, 8'd1,  3'b000},  // R4 run too short, rejected
        {3'b100, 8'd2,  3'b000},  // R4 polarity without level
        {3'b000, 8'd1,  3'b000},  // R4 still closed
        {3'b110, 8'd1,  3'b000},  // R3 first negative
        {3'b110, 8'd1,  3'b000},  // R3 second negative opens
        {3'b110, 8'd1,  3'b110},  // R5 lit on negative
        {3'b000, 8'd1,  3'b010},  // R5 dark on positive
        {3'b110, 8'd1,  3'b110},  // R5
        {3'b000, 8'd17, 3'b010},  // R7 positive run one short
        {3'b110, 8'd1,  3'b110},  // R7 run restarted
        {3'b111, 8'd1,  3'b010},  // R8 disabled data blocked
        {3'b110, 8'd1,  3'b110},  // R5
        {3'b000, 8'd17, 3'b010},  // R6 positive run
        {3'b000, 8'd1,  3'b010},  // R6 last positive sample
        {3'b000, 8'd1,  3'b001},  // R6 start-of-idle
        {3'b000, 8'd3,  3'b000}   // R6 closed again
    };

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic n, input logic l, input logic j);
        @(negedge clk);
        din_neg = n; din_lvl = l; jab_off = j;
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; din_neg = 0; din_lvl = 0; jab_off = 0;
        #1;
        check("R1 emit", emit_on, 1'b0);
        check("R1 act", tx_active, 1'b0);
        check("R1 soi", soi_pulse, 1'b0);
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int bad;
        do_reset();
        // vector walk
        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < int'(VEC[v][10:3]); r++) begin
                drive(VEC[v][13], VEC[v][12], VEC[v][11]);
                check($sformatf("vec%0d emit", v), emit_on, VEC[v][2]);
                check($sformatf("vec%0d act", v), tx_active, VEC[v][1]);
                check($sformatf("vec%0d soi", v), soi_pulse, VEC[v][0]);
            end
        end

        // R2 idle wave after reset; R9 same with disable high
        for (int pass = 0; pass < 2; pass++) begin
            do_reset();
            bad = 0;
            for (int i = 0; i < 150; i++) begin
                drive(1'b0, 1'b0, pass[0]);
                if (emit_on !== logic'((i / 50) % 2)) bad++;
            end
            check(pass == 0 ? "R2 idle wave" : "R9 disable while closed", bad == 0, 1'b1);
        end

        // R8 disable in pass, then R6 end of run while disabled
        do_reset();
        drive(1, 1, 0);
        drive(1, 1, 0);
        drive(1, 1, 0);
        check("R3 open", tx_active, 1'b1);
        bad = 0;
        for (int k = 0; k < 60; k++) begin
            drive(logic'(k % 2 == 0), 1'b1, 1'b1);
            if (emit_on !== logic'((k / 50) % 2)) bad++;
            if (tx_active !== 1'b1) bad++;
        end
        check("R8 idle wave while disabled", bad == 0, 1'b1);
        drive(1, 1, 1);
        bad = 0;
        for (int p = 0; p < 18; p++) begin
            drive(0, 1, 1);
            if (tx_active !== 1'b1) bad++;
        end
        check("R6 active through run", bad == 0, 1'b1);
        drive(0, 1, 1);
        check("R6 soi with disable", soi_pulse, 1'b1);
        check("R6 act low with disable", tx_active, 1'b0);
        drive(0, 1, 1);
        check("R6 soi single", soi_pulse, 1'b0);

        // R1 asynchronous reset mid-packet
        do_reset();
        drive(1, 1, 0);
        drive(1, 1, 0);
        drive(1, 1, 0);
        check("R5 lit before reset", emit_on, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears act", tx_active, 1'b0);
        check("R1 reset clears emit", emit_on, 1'b0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        drive(1, 1, 0);
        check("R1 quiet after reset", tx_active, 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule